// File: doc/BRIEF.md
# Memory Decoder Control Register File

This block is the software-visible register file for a set of address-range decoders on a memory-expansion device. A host reaches it through a 32-bit read/write request port. The block holds a read-only capability word, a global control word and, for each decoder, a group of eight 32-bit slots. Every register applies its own write rules. Reserved bits are forced to zero, read-only bits keep their value, and some slots drop writes altogether.

The block also models the decoder commit handshake. Software sets a commit request bit, and the block reflects it in a committed status bit. A lock bit freezes the decoder's control register once it is set. The block exports each decoder's 64-bit base, 64-bit size and committed flag to the decode logic that uses them. Address matching and interleave routing are not part of this block.

Requests are taken on any cycle in which `reqValid` is high. Each request gets a registered response on the next cycle. Two capability bits are captured at reset, and they decide which control bits software is allowed to change.

Top module: `mem_decoder_regs`

## Requirements
- R1: During reset the capability word is captured from `capWord`. After reset, offset 0x00 reads back that captured word, and every other register, `decBase`, `decSize` and `decCommitted` read as zero.
- R2: Every request yields `respValid` exactly one cycle later. A request with `reqBytes` other than 4 gets `respError`=1 and `respRdata`=0, and changes no state. Write responses and error responses carry `respRdata`=0.
- R3: Decoder n owns byte offsets 0x10+0x20·n to 0x2F+0x20·n. Within that group the slots are: base-low at +0x0, base-high at +0x4, size-low at +0x8 and size-high at +0xC. Bits 27:0 of the low words are written as zero. The high words are fully writable. `decBase`/`decSize` slice n is {high, low}.
- R4: Global control sits at offset 0x04. Bits 31:2 are written as zero and bit 1 is writable. Bit 0 can be written to 1 only when capability bit 10 is set; otherwise it stays 0.
- R5: Decoder control sits at group offset +0x10. Bits 15, 19:16, 23:20 and 31:28 are written as zero. When capability bit 13 is clear, bit 14 and bits 27:24 are also written as zero.
- R6: In decoder control, bits 10, 11 and 12 cannot be written directly. After a write, bit 10 (committed) equals the written bit 9 (commit request). `decCommitted[n]` follows bit 10 of decoder n.
- R7: Once bit 8 (lock) of a decoder control register reads 1, later writes to that register leave it unchanged.
- R8: Writes to group offsets +0x14, +0x18 and +0x1C and to the capability word are discarded. Those slots read their stored value, which is zero for the three group slots.
- R9: Offsets 0x08, 0x0C and any group beyond the last implemented decoder read zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the capability word is loaded while low |
| capWord | input | 32 | Static capability value captured during reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset; bits 1:0 are ignored |
| reqBytes | input | 4 | Access size in bytes; only 4 is legal |
| reqWdata | input | 32 | Write data |
| respValid | output | 1 | Response strobe, one cycle after the request |
| respError | output | 1 | Illegal access size |
| respRdata | output | 32 | Read data |
| decBase | output | NUM_DEC*64 | Per-decoder base address, decoder n in bits 64n+63:64n |
| decSize | output | NUM_DEC*64 | Per-decoder size, same packing |
| decCommitted | output | NUM_DEC | Per-decoder committed flag |

## Verification
The capability-gated masks are the hardest cases to reach. The capability word can only change through a reset, so one configuration can never show both forms of the poison-enable and control-bit masks. The bench therefore runs its stimulus twice, resetting once with capability bits 10 and 13 clear and once with them set. It writes all-ones patterns, so the effect of every mask shows in a single readback. The lock case is reached in two steps: a write sets lock and commit together, and a later write tries to clear them. The bench confirms through both the readback and `decCommitted` that the register did not change.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  localparam int DEC_IDX_W = 3;

  localparam logic [31:0] GLB_RSV_MASK    = 32'hFFFF_FFFC;
  localparam logic [31:0] LOW_RSV_MASK    = 32'h0FFF_FFFF;
  localparam logic [31:0] CTL_RSV_ALWAYS  = 32'hF0FF_8000;
  localparam logic [31:0] CTL_RSV_NO_UIO  = 32'h0F00_4000;
  localparam logic [31:0] CTL_RO_MASK     = 32'h0000_1C00;

  localparam int CTL_LOCK_BIT      = 8;
  localparam int CTL_COMMIT_BIT    = 9;
  localparam int CTL_COMMITTED_BIT = 10;
  localparam int CAP_POISON_BIT    = 10;
  localparam int CAP_UIO_BIT       = 13;

  typedef enum logic [2:0] {
    SLOT_BASE_LO = 3'd0,
    SLOT_BASE_HI = 3'd1,
    SLOT_SIZE_LO = 3'd2,
    SLOT_SIZE_HI = 3'd3,
    SLOT_CTRL    = 3'd4,
    SLOT_TGT_LO  = 3'd5,
    SLOT_TGT_HI  = 3'd6,
    SLOT_RSVD    = 3'd7
  } slot_e;

  typedef struct packed {
    logic                 valid;
    logic                 write;
    logic                 sizeErr;
    logic                 hitCap;
    logic                 hitGlb;
    logic                 hitDec;
    slot_e                slot;
    logic [DEC_IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/memdec_ctrl.sv
module memdec_ctrl
  import memdec_pkg::*;
#(
  parameter int NUM_DEC = 4,
  parameter int ADDR_W  = 10
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqBytes,
  output strobe_t           strb
);
  localparam int GRP_IDX_W = ADDR_W - 5;
  localparam logic [ADDR_W-1:0] GRP_START = ADDR_W'(16);

  logic [ADDR_W-1:0]    relAddr;
  logic [GRP_IDX_W-1:0] grpIdx;
  logic                 inGrpSpace;

  always_comb begin
    relAddr    = reqAddr - GRP_START;
    grpIdx     = relAddr[ADDR_W-1:5];
    inGrpSpace = (reqAddr >= GRP_START);

    strb.valid   = reqValid;
    strb.write   = reqWrite;
    strb.sizeErr = (reqBytes != 4'd4);
    strb.hitCap  = (reqAddr[ADDR_W-1:2] == '0);
    strb.hitGlb  = (reqAddr[ADDR_W-1:2] == (ADDR_W-2)'(1));
    strb.hitDec  = inGrpSpace && (32'(grpIdx) < NUM_DEC);
    strb.slot    = slot_e'(relAddr[4:2]);
    strb.idx     = DEC_IDX_W'(grpIdx);
  end
endmodule

// File: rtl/memdec_datapath.sv
module memdec_datapath
  import memdec_pkg::*;
#(
  parameter int NUM_DEC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           capIn,
  input  strobe_t               strb,
  input  logic [31:0]           wdata,
  output logic                  respValid,
  output logic                  respError,
  output logic [31:0]           respRdata,
  output logic [NUM_DEC*64-1:0] decBase,
  output logic [NUM_DEC*64-1:0] decSize,
  output logic [NUM_DEC-1:0]    decCommitted
);
  logic [31:0] capReg;
  logic [31:0] glbCtrl;
  logic [31:0] baseLo [NUM_DEC];
  logic [31:0] baseHi [NUM_DEC];
  logic [31:0] sizeLo [NUM_DEC];
  logic [31:0] sizeHi [NUM_DEC];
  logic [31:0] ctrlReg [NUM_DEC];

  logic        wrEn;
  logic [31:0] glbNext;
  logic [31:0] ctrlCur;
  logic [31:0] ctrlNext;
  logic [31:0] ctrlRsv;
  logic [31:0] rdWord;

  always_comb begin
    wrEn = strb.valid && strb.write && !strb.sizeErr;

    glbNext = wdata & ~GLB_RSV_MASK;
    if (!capReg[CAP_POISON_BIT]) glbNext[0] = 1'b0;

    ctrlCur = '0;
    for (int d = 0; d < NUM_DEC; d++)
      if (strb.idx == DEC_IDX_W'(d)) ctrlCur = ctrlReg[d];

    ctrlRsv = CTL_RSV_ALWAYS | (capReg[CAP_UIO_BIT] ? 32'h0 : CTL_RSV_NO_UIO);
    ctrlNext = (wdata & ~ctrlRsv & ~CTL_RO_MASK) | (ctrlCur & CTL_RO_MASK);
    ctrlNext[CTL_COMMITTED_BIT] = ctrlNext[CTL_COMMIT_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capReg  <= capIn;
      glbCtrl <= '0;
    end else if (wrEn && strb.hitGlb) begin
      glbCtrl <= glbNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < NUM_DEC; d++) begin
        baseLo[d]  <= '0;
        baseHi[d]  <= '0;
        sizeLo[d]  <= '0;
        sizeHi[d]  <= '0;
        ctrlReg[d] <= '0;
      end
    end else if (wrEn && strb.hitDec) begin
      for (int d = 0; d < NUM_DEC; d++) begin
        if (strb.idx == DEC_IDX_W'(d)) begin
          case (strb.slot)
            SLOT_BASE_LO: baseLo[d] <= wdata & ~LOW_RSV_MASK;
            SLOT_BASE_HI: baseHi[d] <= wdata;
            SLOT_SIZE_LO: sizeLo[d] <= wdata & ~LOW_RSV_MASK;
            SLOT_SIZE_HI: sizeHi[d] <= wdata;
            SLOT_CTRL: if (!ctrlReg[d][CTL_LOCK_BIT]) ctrlReg[d] <= ctrlNext;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdWord = '0;
    if (strb.hitCap) rdWord = capReg;
    else if (strb.hitGlb) rdWord = glbCtrl;
    else if (strb.hitDec) begin
      for (int d = 0; d < NUM_DEC; d++) begin
        if (strb.idx == DEC_IDX_W'(d)) begin
          case (strb.slot)
            SLOT_BASE_LO: rdWord = baseLo[d];
            SLOT_BASE_HI: rdWord = baseHi[d];
            SLOT_SIZE_LO: rdWord = sizeLo[d];
            SLOT_SIZE_HI: rdWord = sizeHi[d];
            SLOT_CTRL:    rdWord = ctrlReg[d];
            default:      rdWord = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respError <= 1'b0;
      respRdata <= '0;
    end else begin
      respValid <= strb.valid;
      respError <= strb.valid && strb.sizeErr;
      respRdata <= (strb.valid && !strb.write && !strb.sizeErr) ? rdWord : '0;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_DEC; g++) begin : gen_out
      assign decBase[g*64 +: 64] = {baseHi[g], baseLo[g]};
      assign decSize[g*64 +: 64] = {sizeHi[g], sizeLo[g]};
      assign decCommitted[g]     = ctrlReg[g][CTL_COMMITTED_BIT];
    end
  endgenerate
endmodule

// File: rtl/mem_decoder_regs.sv
module mem_decoder_regs
  import memdec_pkg::*;
#(
  parameter int NUM_DEC = 4,
  parameter int ADDR_W  = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           capWord,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [3:0]            reqBytes,
  input  logic [31:0]           reqWdata,
  output logic                  respValid,
  output logic                  respError,
  output logic [31:0]           respRdata,
  output logic [NUM_DEC*64-1:0] decBase,
  output logic [NUM_DEC*64-1:0] decSize,
  output logic [NUM_DEC-1:0]    decCommitted
);
  strobe_t strb;

  memdec_ctrl #(.NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W)) u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqBytes (reqBytes),
    .strb     (strb)
  );

  memdec_datapath #(.NUM_DEC(NUM_DEC)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .capIn        (capWord),
    .strb         (strb),
    .wdata        (reqWdata),
    .respValid    (respValid),
    .respError    (respError),
    .respRdata    (respRdata),
    .decBase      (decBase),
    .decSize      (decSize),
    .decCommitted (decCommitted)
  );
endmodule

// File: rtl/memdec_checker.sv
module memdec_checker #(
  parameter int NUM_DEC = 4,
  parameter int ADDR_W  = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reqValid,
  input logic                  reqWrite,
  input logic [ADDR_W-1:0]     reqAddr,
  input logic [3:0]            reqBytes,
  input logic                  respValid,
  input logic                  respError,
  input logic [31:0]           respRdata,
  input logic [NUM_DEC*64-1:0] decBase,
  input logic [NUM_DEC*64-1:0] decSize,
  input logic [NUM_DEC-1:0]    decCommitted
);
  assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> respValid);

  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !respValid);

  assert_bad_size_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqBytes != 4'd4) |=> (respError && respRdata == 32'h0));

  assert_bad_size_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqBytes != 4'd4) |=>
      ($stable(decBase) && $stable(decSize) && $stable(decCommitted)));

  assert_read_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reqValid || !reqWrite) |=>
      ($stable(decBase) && $stable(decSize) && $stable(decCommitted)));

  assert_write_resp_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqWrite) |=> (respRdata == 32'h0));

  genvar g;
  generate
    for (g = 0; g < NUM_DEC; g++) begin : gen_chk
      assert_low_words_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (decBase[g*64 +: 28] == 28'h0) && (decSize[g*64 +: 28] == 28'h0));
    end
  endgenerate
endmodule

bind mem_decoder_regs memdec_checker #(.NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reqValid     (reqValid),
  .reqWrite     (reqWrite),
  .reqAddr      (reqAddr),
  .reqBytes     (reqBytes),
  .respValid    (respValid),
  .respError    (respError),
  .respRdata    (respRdata),
  .decBase      (decBase),
  .decSize      (decSize),
  .decCommitted (decCommitted)
);

// File: tb/tb_mem_decoder_regs.sv
module tb_mem_decoder_regs;
  localparam int NUM_DEC = 4;
  localparam int ADDR_W  = 10;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [31:0]           capWord = '0;
  logic                  reqValid = 1'b0;
  logic                  reqWrite = 1'b0;
  logic [ADDR_W-1:0]     reqAddr = '0;
  logic [3:0]            reqBytes = 4'd4;
  logic [31:0]           reqWdata = '0;
  logic                  respValid;
  logic                  respError;
  logic [31:0]           respRdata;
  logic [NUM_DEC*64-1:0] decBase;
  logic [NUM_DEC*64-1:0] decSize;
  logic [NUM_DEC-1:0]    decCommitted;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        err;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;

  mem_decoder_regs #(.NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .capWord(capWord),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqBytes(reqBytes), .reqWdata(reqWdata),
    .respValid(respValid), .respError(respError), .respRdata(respRdata),
    .decBase(decBase), .decSize(decSize), .decCommitted(decCommitted)
  );

  function automatic int grp(int n, int slot);
    return 16 + 32 * n + slot;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item as each response arrives
  always @(negedge clk) begin
    if (rst_n && respValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected response", {32'h0, respRdata}, 64'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(respError == e.err && respRdata == e.data, e.tag,
              {31'h0, respError, respRdata}, {31'h0, e.err, e.data});
      end
    end
  end

  task automatic access(bit wr, int addr, logic [31:0] wd, logic [3:0] nb,
                        logic [31:0] expData, string tag);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = ADDR_W'(addr);
    reqBytes = nb;
    reqWdata = wd;
    e.err  = (nb != 4'd4);
    e.data = (wr || nb != 4'd4) ? 32'h0 : expData;
    e.tag  = tag;
    expQ.push_back(e);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic wr(int addr, logic [31:0] wd, string tag);
    access(1'b1, addr, wd, 4'd4, 32'h0, tag);
  endtask

  task automatic rd(int addr, logic [31:0] exp, string tag);
    access(1'b0, addr, 32'h0, 4'd4, exp, tag);
  endtask

  task automatic doReset(logic [31:0] cap);
    @(negedge clk);
    rst_n = 1'b0;
    capWord = cap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    // configuration A: capability bits 10 and 13 clear
    doReset(32'h0000_0003);
    check(decBase == '0 && decSize == '0, "R1 reset outputs", decBase[63:0], 64'h0);
    check(decCommitted == '0, "R1 reset committed", 64'(decCommitted), 64'h0);
    rd(0, 32'h0000_0003, "R1 capability readback");
    rd(4, 32'h0, "R1 global ctrl reset");
    rd(grp(0, 16), 32'h0, "R1 decoder ctrl reset");

    wr(4, 32'hFFFF_FFFF, "R4 global write");
    rd(4, 32'h0000_0002, "R4 poison enable gated off");

    wr(grp(0, 0), 32'hFFFF_FFFF, "R3 base low write");
    rd(grp(0, 0), 32'hF000_0000, "R3 base low masked");
    wr(grp(0, 4), 32'h1234_5678, "R3 base high write");
    rd(grp(0, 4), 32'h1234_5678, "R3 base high readback");
    wr(grp(0, 8), 32'hABCD_EF12, "R3 size low write");
    rd(grp(0, 8), 32'hA000_0000, "R3 size low masked");
    wr(grp(0, 12), 32'h0000_0001, "R3 size high write");
    check(decBase[63:0] == 64'h1234_5678_F000_0000, "R3 decBase slice0",
          decBase[63:0], 64'h1234_5678_F000_0000);
    check(decSize[63:0] == 64'h0000_0001_A000_0000, "R3 decSize slice0",
          decSize[63:0], 64'h0000_0001_A000_0000);

    access(1'b1, grp(0, 4), 32'h0000_DEAD, 4'd2, 32'h0, "R2 short write error");
    access(1'b0, grp(0, 4), 32'h0, 4'd8, 32'h0, "R2 wide read error");
    rd(grp(0, 4), 32'h1234_5678, "R2 short write left state");

    wr(grp(0, 16), 32'hFFFF_FEFF, "R5 ctrl write no uio");
    rd(grp(0, 16), 32'h0000_26FF, "R5 R6 ctrl masked no uio");
    check(decCommitted == 4'b0001, "R6 committed set", 64'(decCommitted), 64'h1);
    wr(grp(0, 16), 32'h0000_0000, "R6 ctrl clear");
    rd(grp(0, 16), 32'h0, "R6 commit cleared");
    check(decCommitted == 4'b0000, "R6 committed cleared", 64'(decCommitted), 64'h0);

    for (int s = 20; s <= 28; s += 4) begin
      wr(grp(0, s), 32'hFFFF_FFFF, "R8 discarded slot write");
      rd(grp(0, s), 32'h0, "R8 discarded slot readback");
    end
    wr(0, 32'hFFFF_FFFF, "R8 capability write");
    rd(0, 32'h0000_0003, "R8 capability unchanged");

    wr(grp(4, 4), 32'hFFFF_FFFF, "R9 beyond last decoder write");
    rd(grp(4, 4), 32'h0, "R9 beyond last decoder read");
    rd(8, 32'h0, "R9 unassigned offset read");
    check(decBase[64*NUM_DEC-1:64] == '0, "R9 other decoders untouched",
          decBase[127:64], 64'h0);

    wr(grp(1, 16), 32'h0000_0300, "R7 lock and commit");
    rd(grp(1, 16), 32'h0000_0700, "R7 locked value");
    wr(grp(1, 16), 32'h0000_0000, "R7 write while locked");
    rd(grp(1, 16), 32'h0000_0700, "R7 lock holds");
    check(decCommitted == 4'b0010, "R7 committed held", 64'(decCommitted), 64'h2);

    // configuration B: capability bits 10 and 13 set
    doReset(32'h0000_2400);
    check(decCommitted == '0, "R1 lock cleared by reset", 64'(decCommitted), 64'h0);
    rd(0, 32'h0000_2400, "R1 capability recaptured");
    rd(grp(1, 16), 32'h0, "R1 locked ctrl reset");
    wr(4, 32'hFFFF_FFFF, "R4 global write cap");
    rd(4, 32'h0000_0003, "R4 poison enable allowed");
    access(1'b1, 4, 32'h0, 4'd8, 32'h0, "R2 wide write error");
    rd(4, 32'h0000_0003, "R2 wide write left state");
    wr(grp(2, 16), 32'hFFFF_FEFF, "R5 ctrl write uio");
    rd(grp(2, 16), 32'h0F00_66FF, "R5 ctrl masked uio");
    wr(grp(3, 4), 32'hCAFE_0001, "R3 last decoder base high");
    check(decBase[255:192] == 64'hCAFE_0001_0000_0000, "R3 decBase slice3",
          decBase[255:192], 64'hCAFE_0001_0000_0000);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 all responses seen", 64'(expQ.size()), 64'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule